// File: doc/BRIEF.md
# Addressed SPI Slave Frame Engine

This block is the serial front end of a peripheral that answers fixed 16-bit read frames from a host controller. The host selects the slave with an active-low select line, shifts an instruction byte in, and receives a verification byte at the same time. In the second half of the frame the slave returns one data byte chosen by the instruction. The two upper instruction bits are a chip address, so up to four slaves can share one select line. The data output stays high-impedance until the address is known to match.

The serial clock, select and data pins are brought into the system clock domain through synchronisers, and their edges are detected there; the serial clock is never used as a clock. The slave samples the data input on falling serial-clock edges and launches output bits on rising edges, most significant bit first. A frame is processed when select is released. It counts as valid only if exactly 16 falling edges arrived, the opcode is known, and the frame did not start while the previous one was still being processed. The outcome is reported in the next frame's verification byte. The contents of the diagnostic register arrive on an input bus. After a valid read of that register the block raises a one-cycle clear strobe.

The pad-level tristate buffer is outside the block: it is driven from a data output and an output-enable.

Top module: `addr_spi_frame_engine`

## Requirements
- R1: The data input is sampled on each falling serial-clock edge and output bits change on rising edges. Both directions are most significant bit first. Frame bit k (k = 0..15) is launched on the (k+1)-th rising edge.
- R2: `so_oe` is 0 while select is high, outside a frame, and during frame bits 0 and 1 (the chip-address bits).
- R3: If instruction bits 7:6 differ from the chip address (default 00), `so_oe` stays 0 for the whole frame. The access is then ignored: the error flag is unchanged and no clear strobe is raised.
- R4: For a matching address, frame bits 2..7 carry 1, 0, 1, 0, 1, then the error flag. These are verification-byte bits 5..0.
- R5: The opcode is instruction bits 5:1, and bit 0 is don't-care. Opcode 00000 returns the identifier (default 0xA1) in frame bits 8..15. Opcode 00001 returns the version (default 0x00). Opcode 00100 returns `diag_reg` as sampled at the 7th falling edge.
- R6: Any other opcode returns 0xFF and makes the access invalid.
- R7: An access with a number of falling edges other than 16 during select is invalid.
- R8: A frame whose select falls within PROC_CYCLES system cycles after the previous select release is invalid.
- R9: The error flag is 0 after reset. When an address-matched frame ends, the flag is set to 1 if the frame was invalid and to 0 if it was valid.
- R10: `diag_clr` pulses high for exactly one cycle after a valid opcode-00100 frame, and at no other time.
- R11: While `spi_en` is 0 the engine is held in its default state: `so_oe` is 0, the error flag is 0, any frame in progress is dropped, and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_en | input | 1 | Interface enable, synchronous to clk; 0 holds the engine in its default state |
| sck | input | 1 | Serial clock pin (asynchronous) |
| ss_n | input | 1 | Active-low select pin (asynchronous) |
| si | input | 1 | Serial data in (asynchronous) |
| diag_reg | input | 8 | Current diagnostic register contents |
| so_data | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial data pad (0 = high impedance) |
| diag_clr | output | 1 | One-cycle clear strobe for the diagnostic register |

## Verification
Assertions check the following on every cycle:
- the output enable stays low outside a frame and is never high unless the address matched;
- the clear strobe lasts a single cycle and only follows an address-matched frame of exactly 16 edges;
- the error flag changes only at a frame end;
- the enable input forces the quiet state.

Only the bench scenarios can show that the returned bytes, the verification pattern, and the error-flag history across consecutive frames match the instruction sequence. The same applies to the rejection of short, long, early and unknown-opcode frames.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int FRAME_BITS = 16;
  localparam int HDR_BITS   = 8;
  localparam int ADDR_BITS  = 2;
  localparam int OP_BITS    = 5;
  localparam int BYTE_W     = 8;

  // opcode field values (instruction bits 5:1)
  typedef enum logic [OP_BITS-1:0] {
    OP_IDENT   = 5'b00000,
    OP_VERSION = 5'b00001,
    OP_DIAG    = 5'b00100
  } opcode_e;

  // fixed part of the verification byte, sent before the error flag
  localparam logic [4:0] VERIF_PATTERN = 5'b10101;
  localparam logic [BYTE_W-1:0] UNUSED_FILL = 8'hFF;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] lvl
);
  for (genvar g = 0; g < N; g++) begin : g_chain
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= {STAGES{RST_VAL[g]}};
      else     sh <= {sh[STAGES-2:0], pin_in[g]};
    end
    assign lvl[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
  parameter int N = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev;
  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end
  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise[g] = lvl[g] & ~prev[g];
    assign fall[g] = ~lvl[g] & prev[g];
  end
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_pkg::*;
#(
  parameter logic [ADDR_BITS-1:0] CHIP_ADDR    = 2'b00,
  parameter logic [BYTE_W-1:0]    IDENT_BYTE   = 8'hA1,
  parameter logic [BYTE_W-1:0]    VERSION_BYTE = 8'h00,
  parameter int                   PROC_CYCLES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sck_fall,
  input  logic              ss_fall,
  input  logic              ss_rise,
  input  logic              si_lvl,
  input  logic [BYTE_W-1:0] diag_in,
  output logic              frame_act,
  output logic              addr_ok,
  output logic              trans_f,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              diag_clr
);
  localparam int CNT_W  = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_BITS);
  localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(ADDR_BITS + OP_BITS);
  localparam int BUSY_W = (PROC_CYCLES < 2) ? 1 : $clog2(PROC_CYCLES + 1);

  logic [CNT_W-1:0]   fall_cnt, cnt_nx;
  logic [3:0]         ins_q;
  logic [4:0]         ins_nx;
  logic               op_ok_q, op_diag_q, late_q;
  logic [BUSY_W-1:0]  busy_cnt;
  logic [BYTE_W-1:0]  dec_byte;
  logic               dec_ok, dec_diag, frame_valid;

  assign cnt_nx = fall_cnt + CNT_W'(1);
  assign ins_nx = {ins_q, si_lvl};

  // opcode decode on the bits as they complete
  always_comb begin
    dec_byte = UNUSED_FILL;
    dec_ok   = 1'b1;
    dec_diag = 1'b0;
    case (ins_nx)
      OP_IDENT:   dec_byte = IDENT_BYTE;
      OP_VERSION: dec_byte = VERSION_BYTE;
      OP_DIAG: begin
        dec_byte = diag_in;
        dec_diag = 1'b1;
      end
      default:    dec_ok = 1'b0;
    endcase
  end

  assign frame_valid = (fall_cnt == CNT_FULL) && op_ok_q && !late_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      frame_act <= 1'b0;
      addr_ok   <= 1'b0;
      trans_f   <= 1'b0;
      rd_byte   <= UNUSED_FILL;
      diag_clr  <= 1'b0;
      fall_cnt  <= '0;
      ins_q     <= '0;
      op_ok_q   <= 1'b0;
      op_diag_q <= 1'b0;
      late_q    <= 1'b0;
      busy_cnt  <= '0;
    end else begin
      diag_clr <= 1'b0;
      if (busy_cnt != '0) busy_cnt <= busy_cnt - BUSY_W'(1);
      if (ss_fall) begin
        frame_act <= 1'b1;
        fall_cnt  <= '0;
        ins_q     <= '0;
        addr_ok   <= 1'b0;
        op_ok_q   <= 1'b0;
        op_diag_q <= 1'b0;
        late_q    <= (busy_cnt != '0);
        rd_byte   <= UNUSED_FILL;
      end else if (frame_act && sck_fall) begin
        ins_q <= ins_nx[3:0];
        if (fall_cnt != CNT_MAX) fall_cnt <= cnt_nx;
        if (cnt_nx == CNT_ADDR) addr_ok <= (ins_nx[1:0] == CHIP_ADDR);
        if (cnt_nx == CNT_OP) begin
          rd_byte   <= dec_byte;
          op_ok_q   <= dec_ok;
          op_diag_q <= dec_diag;
        end
      end
      if (ss_rise && frame_act) begin
        frame_act <= 1'b0;
        busy_cnt  <= BUSY_W'(PROC_CYCLES);
        if (addr_ok) begin
          trans_f  <= !frame_valid;
          diag_clr <= frame_valid && op_diag_q;
        end
      end
    end
  end

  assert_clr_single_R10: assert property (@(posedge clk) disable iff (rst)
    diag_clr |=> !diag_clr);
  assert_clr_matched_R3: assert property (@(posedge clk) disable iff (rst)
    diag_clr |-> addr_ok);
  assert_clr_len_R7: assert property (@(posedge clk) disable iff (rst)
    diag_clr |-> (fall_cnt == CNT_FULL));
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (en && !(ss_rise && frame_act)) |=> $stable(trans_f));
endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path
  import spi_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sck_rise,
  input  logic              ss_fall,
  input  logic              ss_rise,
  input  logic              frame_act,
  input  logic              addr_ok,
  input  logic              trans_f,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              so_data,
  output logic              so_oe
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] IDX_ADDR = CNT_W'(ADDR_BITS);
  localparam logic [CNT_W-1:0] IDX_DATA = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] IDX_END  = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0] rise_cnt;
  logic [5:0]       hdr_sh;
  logic [BYTE_W-1:0] dat_sh;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      rise_cnt <= '0;
      hdr_sh   <= '0;
      dat_sh   <= '0;
      so_data  <= 1'b0;
      so_oe    <= 1'b0;
    end else if (ss_fall) begin
      rise_cnt <= '0;
      hdr_sh   <= {VERIF_PATTERN, trans_f};
      so_data  <= 1'b0;
      so_oe    <= 1'b0;
    end else if (!frame_act || ss_rise) begin
      so_data <= 1'b0;
      so_oe   <= 1'b0;
    end else if (sck_rise) begin
      if (rise_cnt != CNT_MAX) rise_cnt <= rise_cnt + CNT_W'(1);
      if (rise_cnt < IDX_ADDR || rise_cnt >= IDX_END) begin
        so_data <= 1'b0;
        so_oe   <= 1'b0;
      end else if (rise_cnt < IDX_DATA) begin
        so_data <= hdr_sh[5];
        hdr_sh  <= {hdr_sh[4:0], 1'b0};
        so_oe   <= addr_ok;
      end else if (rise_cnt == IDX_DATA) begin
        so_data <= rd_byte[BYTE_W-1];
        dat_sh  <= {rd_byte[BYTE_W-2:0], 1'b0};
        so_oe   <= addr_ok;
      end else begin
        so_data <= dat_sh[BYTE_W-1];
        dat_sh  <= {dat_sh[BYTE_W-2:0], 1'b0};
        so_oe   <= addr_ok;
      end
    end
  end

  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !frame_act |=> !so_oe);
  assert_oe_matched_R3: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> addr_ok);
endmodule

// File: rtl/addr_spi_frame_engine.sv
module addr_spi_frame_engine
  import spi_frame_pkg::*;
#(
  parameter int                   SYNC_STAGES  = 2,
  parameter int                   PROC_CYCLES  = 4,
  parameter logic [ADDR_BITS-1:0] CHIP_ADDR    = 2'b00,
  parameter logic [BYTE_W-1:0]    IDENT_BYTE   = 8'hA1,
  parameter logic [BYTE_W-1:0]    VERSION_BYTE = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_en,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              si,
  input  logic [BYTE_W-1:0] diag_reg,
  output logic              so_data,
  output logic              so_oe,
  output logic              diag_clr
);
  // pin order: {si, ss_n, sck}; select idles high
  logic [2:0] pin_lvl;
  logic [1:0] e_rise, e_fall;
  logic frame_act, addr_ok, trans_f;
  logic [BYTE_W-1:0] rd_byte;

  spi_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .pin_in({si, ss_n, sck}), .lvl(pin_lvl));

  spi_edge_det #(.N(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst(rst), .lvl(pin_lvl[1:0]), .rise(e_rise), .fall(e_fall));

  // select is active low: its frame start is a falling edge of ss_n
  spi_frame_ctrl #(
    .CHIP_ADDR(CHIP_ADDR), .IDENT_BYTE(IDENT_BYTE),
    .VERSION_BYTE(VERSION_BYTE), .PROC_CYCLES(PROC_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .en(spi_en),
    .sck_fall(e_fall[0]), .ss_fall(e_fall[1]), .ss_rise(e_rise[1]),
    .si_lvl(pin_lvl[2]), .diag_in(diag_reg),
    .frame_act(frame_act), .addr_ok(addr_ok), .trans_f(trans_f),
    .rd_byte(rd_byte), .diag_clr(diag_clr));

  spi_tx_path u_tx (
    .clk(clk), .rst(rst), .en(spi_en),
    .sck_rise(e_rise[0]), .ss_fall(e_fall[1]), .ss_rise(e_rise[1]),
    .frame_act(frame_act), .addr_ok(addr_ok), .trans_f(trans_f),
    .rd_byte(rd_byte), .so_data(so_data), .so_oe(so_oe));

  assert_en_default_R11: assert property (@(posedge clk) disable iff (rst)
    !spi_en |=> (!so_oe && !diag_clr));
endmodule

// File: tb/addr_spi_frame_engine_test.sv
module addr_spi_frame_engine_test;
  logic clk = 1'b0;
  logic rst, spi_en, sck, ss_n, si;
  logic [7:0] diag_reg;
  logic so_data, so_oe, diag_clr;
  int n_cmp = 0, n_bad = 0, clr_cnt = 0;
  logic [15:0] m_data, m_oe;

  always #2.5 clk = ~clk;  // 200 MHz

  addr_spi_frame_engine uut (
    .clk(clk), .rst(rst), .spi_en(spi_en), .sck(sck), .ss_n(ss_n), .si(si),
    .diag_reg(diag_reg), .so_data(so_data), .so_oe(so_oe), .diag_clr(diag_clr));

  always @(posedge clk) if (!rst && diag_clr) clr_cnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one access: nfall serial-clock pulses, then select release and gap cycles
  task automatic frame(input logic [15:0] w, input int nfall, input int gap);
    m_data = '0; m_oe = '0;
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nfall; i++) begin
      si = (i < 16) ? w[15-i] : 1'b0;
      sck = 1'b1;
      repeat (6) @(negedge clk);
      if (i < 16) begin
        m_data[15-i] = so_data;
        m_oe[15-i]   = so_oe;
      end
      repeat (2) @(negedge clk);
      sck = 1'b0;
      repeat (8) @(negedge clk);
    end
    ss_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic read_chk(input string tag, input logic [7:0] instr,
                          input logic [7:0] exp_data, input logic exp_tf);
    frame({instr, 8'h5A}, 16, 20);
    check({tag, " R2 oe window"}, m_oe, 16'h3FFF);
    check({tag, " R4 verification"}, m_data[13:8], {5'b10101, exp_tf});
    check({tag, " R1 data"}, m_data[7:0], exp_data);
  endtask

  task automatic test_reset;
    check("R2 reset oe", so_oe, 0);
    check("R10 reset strobe", diag_clr, 0);
  endtask

  task automatic test_ident;
    read_chk("R5 ident", 8'h00, 8'hA1, 1'b0);
    read_chk("R5 ident bit0 dc", 8'h01, 8'hA1, 1'b0);
  endtask

  task automatic test_version;
    read_chk("R5 version", 8'h03, 8'h00, 1'b0);
    read_chk("R5 version bit0 dc", 8'h02, 8'h00, 1'b0);
  endtask

  task automatic test_diag;
    int c0;
    diag_reg = 8'h5C;
    c0 = clr_cnt;
    read_chk("R5 diag", 8'h08, 8'h5C, 1'b0);
    check("R10 one strobe", clr_cnt, c0 + 1);
    diag_reg = 8'hC3;
    read_chk("R5 diag b", 8'h09, 8'hC3, 1'b0);
    check("R10 second strobe", clr_cnt, c0 + 2);
    read_chk("R10 ident no strobe", 8'h00, 8'hA1, 1'b0);
    check("R10 no strobe on ident", clr_cnt, c0 + 2);
  endtask

  task automatic test_unused;
    int c0 = clr_cnt;
    read_chk("R6 unused", 8'h06, 8'hFF, 1'b0);
    read_chk("R9 flag after unused", 8'h00, 8'hA1, 1'b1);
    read_chk("R9 flag cleared", 8'h00, 8'hA1, 1'b0);
    check("R6 no strobe", clr_cnt, c0);
  endtask

  task automatic test_length;
    int c0 = clr_cnt;
    frame({8'h08, 8'h00}, 15, 20);
    check("R7 short no strobe", clr_cnt, c0);
    read_chk("R7 after short", 8'h00, 8'hA1, 1'b1);
    frame({8'h08, 8'h00}, 17, 20);
    check("R7 long no strobe", clr_cnt, c0);
    read_chk("R7 after long", 8'h00, 8'hA1, 1'b1);
    read_chk("R7 recovered", 8'h00, 8'hA1, 1'b0);
  endtask

  task automatic test_mismatch;
    int c0;
    frame({8'h06, 8'h00}, 16, 20);  // leaves error flag set
    c0 = clr_cnt;
    frame({8'h48, 8'h00}, 16, 20);
    check("R3 oe off", m_oe, 16'h0000);
    check("R3 no strobe", clr_cnt, c0);
    read_chk("R3 flag kept", 8'h00, 8'hA1, 1'b1);
    frame({8'hC8, 8'h00}, 16, 20);
    check("R3 oe off addr 11", m_oe, 16'h0000);
    read_chk("R3 flag cleared by valid", 8'h00, 8'hA1, 1'b0);
  endtask

  task automatic test_busy;
    int c0 = clr_cnt;
    frame({8'h00, 8'h00}, 16, 2);
    frame({8'h08, 8'h00}, 16, 20);
    check("R8 early frame no strobe", clr_cnt, c0);
    read_chk("R8 flag after early", 8'h00, 8'hA1, 1'b1);
    read_chk("R8 recovered", 8'h00, 8'hA1, 1'b0);
  endtask

  task automatic test_enable;
    int c0;
    frame({8'h06, 8'h00}, 16, 20);
    spi_en = 1'b0;
    c0 = clr_cnt;
    frame({8'h08, 8'h00}, 16, 20);
    check("R11 oe held off", m_oe, 16'h0000);
    check("R11 no strobe", clr_cnt, c0);
    spi_en = 1'b1;
    repeat (4) @(negedge clk);
    read_chk("R11 flag reset", 8'h00, 8'hA1, 1'b0);
  endtask

  task automatic test_idle;
    logic seen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      sck = 1'b1;
      repeat (6) @(negedge clk);
      seen |= so_oe;
      sck = 1'b0;
      repeat (6) @(negedge clk);
    end
    check("R2 idle clocks", seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; spi_en = 1'b1; sck = 1'b0; ss_n = 1'b1; si = 1'b0; diag_reg = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    test_reset();
    test_ident();
    test_version();
    test_diag();
    test_unused();
    test_length();
    test_mismatch();
    test_busy();
    test_enable();
    test_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule